// File: doc/BRIEF.md
# Synchronous DRAM Read Burst Sequencer with Interruption Handling

This block is the device-side read data-path scheduler of a two-bank synchronous DRAM. It takes one decoded column or bank command per clock, each with a bank and a starting column. For every read it schedules output beats after the CAS latency, walks the column address through the burst, and presents an output enable together with the bank and column that the storage array must put on the data pins. All timing is set by parameters: the CAS latency (1, 2 or 3), the burst length (1, 2, 4 or 8) and the deactivate-to-high-impedance delay.

A read burst in progress can be cut short in three ways. A newer read takes the pins over as soon as its own latency has elapsed. A write ends the read at once and also discards any read that is still waiting out its latency. A bank deactivate stops the output after a fixed delay, unless the burst has already ended. A data mask input, which takes effect two cycles after it is sampled, gates the output enable so that a controller can keep read data off the pins around a write. Reads and writes that carry auto-precharge also raise a one-cycle precharge request for their bank once their last beat has passed.

Top module: `sdr_rd_seq`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `dq_oe` and `pre_req` are low.
- R2: A read (`cmd_code` 1, or 2 for read with auto-precharge) sampled in cycle c with no later interruption yields beats in cycles c+CAS_LAT through c+CAS_LAT+BURST_LEN-1, with `dq_bank` equal to the command bank on every beat.
- R3: Beat j of a burst has a column whose low log2(BURST_LEN) bits are (start + j) modulo BURST_LEN and whose upper bits equal those of the start column (sequential wrap inside the aligned block).
- R4: A read sampled in cycle c while an earlier burst is active or pending lets the earlier burst keep its beats before cycle c+CAS_LAT; from c+CAS_LAT on only the new burst is output. Reads in consecutive cycles are legal.
- R5: A write (`cmd_code` 3, or 4 with auto-precharge) sampled in cycle c removes every read beat after cycle c, including beats of reads still waiting out their latency.
- R6: `dq_oe` is high in cycle t only when a beat is scheduled for t and `dqm` sampled in cycle t-2 was low; otherwise it is low.
- R7: A deactivate (`cmd_code` 5 for the bank on `cmd_bank`, 6 for all banks) sampled in cycle c while a burst of a matching bank is active removes that burst's beats from cycle c+CLOSE_HZ on; a burst ending earlier is unaffected.
- R8: A read with auto-precharge (`cmd_code` 2) whose final beat is scheduled (mask not considered) raises `pre_req` for one cycle right after that beat, with `pre_bank` equal to its bank; if its final beat was removed, no pulse is raised.
- R9: A write with auto-precharge (`cmd_code` 4) sampled in cycle c raises `pre_req` in cycle c+BURST_LEN with `pre_bank` equal to its bank, unless a read or write (`cmd_code` 1 to 4) is sampled in cycles c+1 through c+BURST_LEN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_code | input | 3 | Decoded command: 0 idle, 1 read, 2 read+auto-precharge, 3 write, 4 write+auto-precharge, 5 deactivate bank, 6 deactivate all |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| cmd_col | input | COL_W | Starting column of a read or write |
| dqm | input | 1 | Data mask, effective two cycles after sampling |
| dq_oe | output | 1 | Output enable for the data pins |
| dq_bank | output | BANK_W | Bank of the current beat |
| dq_col | output | COL_W | Column of the current beat |
| pre_req | output | 1 | One-cycle auto-precharge request |
| pre_bank | output | BANK_W | Bank for the precharge request |

## Verification
Directed sequences try the main scheduling with an isolated read starting mid-block, so the wrap of the column walk is seen, and with a second read one and two cycles after the first, which separates a design that lets the old burst finish or drops it at once from one that hands over exactly at the new latency. A write placed inside a masked read shows that beats stop after the write cycle and that the precharge request of an interrupted auto-precharge read vanishes. Deactivates placed early and late in a burst tell the delay-bound stop from the natural end, and a write with auto-precharge followed by a read checks the cancelled pulse. A long stretch of random reads, writes and masks with random banks and columns then checks the overlapping cases against a cycle table computed in the bench.

// File: rtl/sdr_rd_pkg.sv
// Shared command encoding for the read burst sequencer.
// Assumes commands arrive already decoded, at most one per clock.
package sdr_rd_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE      = 3'd0,
        CMD_READ      = 3'd1,
        CMD_READ_AP   = 3'd2,
        CMD_WRITE     = 3'd3,
        CMD_WRITE_AP  = 3'd4,
        CMD_CLOSE     = 3'd5,
        CMD_CLOSE_ALL = 3'd6
    } sdr_cmd_e;

    function automatic logic is_read_cmd(sdr_cmd_e c);
        return (c == CMD_READ) || (c == CMD_READ_AP);
    endfunction

    function automatic logic is_write_cmd(sdr_cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_WRITE_AP);
    endfunction

endpackage

// File: rtl/sdr_rd_launch_pipe.sv
// Delays an accepted read by CAS_LAT-1 clocks so that the burst engine
// loads it exactly when its first beat is due. With CAS_LAT of 1 the
// read passes straight through. A flush empties every stage.
// Assumes at most one read enters per clock.
module sdr_rd_launch_pipe #(
    parameter int CAS_LAT = 3,
    parameter int BANK_W  = 1,
    parameter int COL_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_ap,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [COL_W-1:0]  in_col,
    input  logic              flush,
    output logic              out_valid,
    output logic              out_ap,
    output logic [BANK_W-1:0] out_bank,
    output logic [COL_W-1:0]  out_col
);
    localparam int DEPTH = (CAS_LAT > 1) ? CAS_LAT - 1 : 1;

    generate
        if (CAS_LAT == 1) begin : g_direct
            // Zero-stage variant: the read starts on the edge that samples it.
            assign out_valid = in_valid & ~flush;
            assign out_ap    = in_ap;
            assign out_bank  = in_bank;
            assign out_col   = in_col;
        end else begin : g_stages
            logic [DEPTH-1:0] st_valid;
            logic [DEPTH-1:0] st_ap;
            logic [BANK_W-1:0] st_bank [DEPTH];
            logic [COL_W-1:0]  st_col  [DEPTH];

            // Shift reads toward the engine; a write clears them all.
            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    st_valid <= '0;
                end else begin
                    st_valid[0] <= in_valid;
                    for (int i = 1; i < DEPTH; i++) begin
                        st_valid[i] <= st_valid[i-1];
                    end
                end
            end

            // Payload shifts without reset; it is qualified by st_valid.
            always_ff @(posedge clk) begin
                st_ap[0]   <= in_ap;
                st_bank[0] <= in_bank;
                st_col[0]  <= in_col;
                for (int i = 1; i < DEPTH; i++) begin
                    st_ap[i]   <= st_ap[i-1];
                    st_bank[i] <= st_bank[i-1];
                    st_col[i]  <= st_col[i-1];
                end
            end

            assign out_valid = st_valid[DEPTH-1];
            assign out_ap    = st_ap[DEPTH-1];
            assign out_bank  = st_bank[DEPTH-1];
            assign out_col   = st_col[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/sdr_rd_burst_engine.sv
// Holds the burst currently on the pins: one beat per clock, column
// walking sequentially inside the aligned burst block. A write kills it
// at once; a deactivate kills it CLOSE_HZ clocks after being sampled.
// Assumes BURST_LEN is a power of two and CLOSE_HZ is at least 1.
module sdr_rd_burst_engine #(
    parameter int BURST_LEN = 4,
    parameter int CLOSE_HZ  = 2,
    parameter int BANK_W    = 1,
    parameter int COL_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic              start_ap,
    input  logic [BANK_W-1:0] start_bank,
    input  logic [COL_W-1:0]  start_col,
    input  logic              kill_wr,
    input  logic              close_req,
    input  logic              close_all,
    input  logic [BANK_W-1:0] close_bank,
    output logic              beat_valid,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_col,
    output logic              ap_fire,
    output logic [BANK_W-1:0] ap_bank
);
    localparam int IDX_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [COL_W-1:0] WRAP_MASK = COL_W'(BURST_LEN - 1);
    localparam int HZ_W    = $clog2(CLOSE_HZ + 1);
    localparam int HZ_LOAD = (CLOSE_HZ >= 2) ? CLOSE_HZ - 2 : 0;

    logic              cur_ap;
    logic [IDX_W-1:0]  cur_idx;
    logic              last_beat;
    logic              hz_armed, hz_all;
    logic [BANK_W-1:0] hz_bank;
    logic [HZ_W-1:0]   hz_cnt;
    logic              hz_now, hz_late, hz_kill;
    logic [COL_W-1:0]  col_next;

    // Beat position and the next column inside the aligned block.
    always_comb begin
        last_beat = (cur_idx == IDX_W'(BURST_LEN - 1));
        col_next  = (beat_col & ~WRAP_MASK) | ((beat_col + 1'b1) & WRAP_MASK);
    end

    // Deactivate stop decision: immediate for a one-cycle delay, else timed.
    always_comb begin
        hz_now  = close_req && (CLOSE_HZ == 1) && (close_all || close_bank == beat_bank);
        hz_late = hz_armed && (hz_cnt == '0) && (hz_all || hz_bank == beat_bank);
        hz_kill = beat_valid && (hz_now || hz_late);
    end

    // Deactivate delay timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hz_armed <= 1'b0;
            hz_cnt   <= '0;
            hz_all   <= 1'b0;
            hz_bank  <= '0;
        end else if (close_req && CLOSE_HZ > 1) begin
            hz_armed <= 1'b1;
            hz_cnt   <= HZ_W'(HZ_LOAD);
            hz_all   <= close_all;
            hz_bank  <= close_bank;
        end else if (hz_armed) begin
            if (hz_cnt == '0) hz_armed <= 1'b0;
            else              hz_cnt   <= hz_cnt - 1'b1;
        end
    end

    // Burst state: write kill, then new start, then deactivate, then step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_valid <= 1'b0;
            cur_ap     <= 1'b0;
            cur_idx    <= '0;
            beat_bank  <= '0;
            beat_col   <= '0;
        end else if (kill_wr) begin
            beat_valid <= 1'b0;
        end else if (start_valid) begin
            beat_valid <= 1'b1;
            cur_ap     <= start_ap;
            cur_idx    <= '0;
            beat_bank  <= start_bank;
            beat_col   <= start_col;
        end else if (hz_kill) begin
            beat_valid <= 1'b0;
        end else if (beat_valid && !last_beat) begin
            cur_idx  <= cur_idx + 1'b1;
            beat_col <= col_next;
        end else begin
            beat_valid <= 1'b0;
        end
    end

    // The final beat of an auto-precharge read is on the pins this cycle.
    assign ap_fire = beat_valid && last_beat && cur_ap;
    assign ap_bank = beat_bank;
endmodule

// File: rtl/sdr_wr_ap_tracker.sv
// Counts out the burst of a write with auto-precharge and fires on the
// edge after which its precharge request is due. A later read or write
// inside that burst cancels it; a new write with auto-precharge restarts.
// Assumes write data starts in the command cycle.
module sdr_wr_ap_tracker #(
    parameter int BURST_LEN = 4,
    parameter int BANK_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ap,
    input  logic              col_cmd,
    input  logic [BANK_W-1:0] in_bank,
    output logic              fire,
    output logic [BANK_W-1:0] fire_bank
);
    localparam int CNT_W = $clog2(BURST_LEN + 1);

    logic              armed;
    logic [CNT_W-1:0]  cnt;
    logic [BANK_W-1:0] bank_q;

    // Fire: at once for single-beat bursts, else when the count runs out.
    always_comb begin
        fire      = (wr_ap && BURST_LEN == 1) || (armed && cnt == CNT_W'(1) && !col_cmd);
        fire_bank = (wr_ap && BURST_LEN == 1) ? in_bank : bank_q;
    end

    // Arm, cancel and count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            cnt    <= '0;
            bank_q <= '0;
        end else if (wr_ap && BURST_LEN > 1) begin
            armed  <= 1'b1;
            cnt    <= CNT_W'(BURST_LEN - 1);
            bank_q <= in_bank;
        end else if (col_cmd) begin
            armed <= 1'b0;
        end else if (armed) begin
            if (cnt == CNT_W'(1)) armed <= 1'b0;
            else                  cnt   <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sdr_rd_seq.sv
// Top of the read burst sequencer. Splits decoded commands into the read
// launch pipe, the burst engine and the write auto-precharge tracker,
// delays the data mask by two clocks and registers the precharge request.
// Assumes one decoded command per clock and legal command spacing.
module sdr_rd_seq #(
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 4,
    parameter int CLOSE_HZ  = 2,
    parameter int COL_W     = 9,
    parameter int BANK_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_code,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              dqm,
    output logic              dq_oe,
    output logic [BANK_W-1:0] dq_bank,
    output logic [COL_W-1:0]  dq_col,
    output logic              pre_req,
    output logic [BANK_W-1:0] pre_bank
);
    import sdr_rd_pkg::*;

    sdr_cmd_e          cmd;
    logic              rd_cmd, wr_cmd, close_cmd;
    logic              start_valid, start_ap;
    logic [BANK_W-1:0] start_bank;
    logic [COL_W-1:0]  start_col;
    logic              beat_valid;
    logic              rd_ap_fire, wr_ap_fire;
    logic [BANK_W-1:0] rd_ap_bank, wr_ap_bank;
    logic              dqm_d1, dqm_d2;

    // Command classification.
    always_comb begin
        cmd       = sdr_cmd_e'(cmd_code);
        rd_cmd    = is_read_cmd(cmd);
        wr_cmd    = is_write_cmd(cmd);
        close_cmd = (cmd == CMD_CLOSE) || (cmd == CMD_CLOSE_ALL);
    end

    sdr_rd_launch_pipe #(
        .CAS_LAT (CAS_LAT),
        .BANK_W  (BANK_W),
        .COL_W   (COL_W)
    ) i_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rd_cmd),
        .in_ap     (cmd == CMD_READ_AP),
        .in_bank   (cmd_bank),
        .in_col    (cmd_col),
        .flush     (wr_cmd),
        .out_valid (start_valid),
        .out_ap    (start_ap),
        .out_bank  (start_bank),
        .out_col   (start_col)
    );

    sdr_rd_burst_engine #(
        .BURST_LEN (BURST_LEN),
        .CLOSE_HZ  (CLOSE_HZ),
        .BANK_W    (BANK_W),
        .COL_W     (COL_W)
    ) i_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (start_valid),
        .start_ap    (start_ap),
        .start_bank  (start_bank),
        .start_col   (start_col),
        .kill_wr     (wr_cmd),
        .close_req   (close_cmd),
        .close_all   (cmd == CMD_CLOSE_ALL),
        .close_bank  (cmd_bank),
        .beat_valid  (beat_valid),
        .beat_bank   (dq_bank),
        .beat_col    (dq_col),
        .ap_fire     (rd_ap_fire),
        .ap_bank     (rd_ap_bank)
    );

    sdr_wr_ap_tracker #(
        .BURST_LEN (BURST_LEN),
        .BANK_W    (BANK_W)
    ) i_wr_ap (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ap     (cmd == CMD_WRITE_AP),
        .col_cmd   (rd_cmd || wr_cmd),
        .in_bank   (cmd_bank),
        .fire      (wr_ap_fire),
        .fire_bank (wr_ap_bank)
    );

    // Two-clock data mask latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dqm_d1 <= 1'b1;
            dqm_d2 <= 1'b1;
        end else begin
            dqm_d1 <= dqm;
            dqm_d2 <= dqm_d1;
        end
    end

    // One-cycle precharge request, write tracker taking the bank if both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_req  <= 1'b0;
            pre_bank <= '0;
        end else begin
            pre_req  <= rd_ap_fire || wr_ap_fire;
            pre_bank <= wr_ap_fire ? wr_ap_bank : rd_ap_bank;
        end
    end

    assign dq_oe = beat_valid & ~dqm_d2;
endmodule

// File: rtl/sdr_rd_seq_chk.sv
// Protocol checker for the read burst sequencer, bound to every instance.
// Relates commands and mask to the output pins and to the burst engine.
module sdr_rd_seq_chk #(
    parameter int BURST_LEN = 4,
    parameter int COL_W     = 9,
    parameter int BANK_W    = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd_code,
    input logic              dqm,
    input logic              dq_oe,
    input logic [BANK_W-1:0] dq_bank,
    input logic [COL_W-1:0]  dq_col,
    input logic              pre_req,
    input logic              beat_valid,
    input logic              start_valid
);
    localparam logic [COL_W-1:0] WMASK = COL_W'(BURST_LEN - 1);

    // R1: outputs quiet in the first cycle after reset release.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!dq_oe && !pre_req));

    // R6: enable only when the mask sampled two cycles earlier was low.
    p_oe_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !$past(dqm, 2));

    // R5: no read beat in the cycle after a write.
    p_write_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 3'd3 || cmd_code == 3'd4) |=> !dq_oe);

    // R3: consecutive beats of one burst step the column inside the block.
    p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && $past(beat_valid) && !$past(start_valid)) |->
            (((dq_col & ~WMASK) == ($past(dq_col) & ~WMASK)) &&
             ((dq_col & WMASK) == (($past(dq_col) + 1'b1) & WMASK)) &&
             $stable(dq_bank)));
endmodule

bind sdr_rd_seq sdr_rd_seq_chk #(
    .BURST_LEN (BURST_LEN),
    .COL_W     (COL_W),
    .BANK_W    (BANK_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_code    (cmd_code),
    .dqm         (dqm),
    .dq_oe       (dq_oe),
    .dq_bank     (dq_bank),
    .dq_col      (dq_col),
    .pre_req     (pre_req),
    .beat_valid  (beat_valid),
    .start_valid (start_valid)
);

// File: tb/test_sdr_rd_seq.sv
// Bench: a per-cycle command program (directed scenarios, then seeded
// random traffic) is turned into an expected output table by bench
// functions written from the requirements, then replayed and compared.
module test_sdr_rd_seq;
    localparam int CL    = 3;
    localparam int BL    = 4;
    localparam int HZ    = 2;
    localparam int CW    = 9;
    localparam int NCYC  = 600;
    localparam logic [CW-1:0] WM = CW'(BL - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd_code = 3'd0;
    logic          cmd_bank = 1'b0;
    logic [CW-1:0] cmd_col = '0;
    logic          dqm = 1'b0;
    logic          dq_oe, dq_bank, pre_req, pre_bank;
    logic [CW-1:0] dq_col;

    logic [2:0]    p_cmd  [NCYC];
    logic          p_bank [NCYC];
    logic [CW-1:0] p_col  [NCYC];
    logic          p_dqm  [NCYC];
    string         tag    [NCYC];
    logic          e_beat [NCYC];
    logic          e_bank [NCYC];
    logic [CW-1:0] e_col  [NCYC];
    int            e_own  [NCYC];
    logic          e_pre  [NCYC];
    logic          e_preb [NCYC];

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sdr_rd_seq #(.CAS_LAT(CL), .BURST_LEN(BL), .CLOSE_HZ(HZ), .COL_W(CW), .BANK_W(1)) i_sdr_rd_seq (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .dqm(dqm), .dq_oe(dq_oe), .dq_bank(dq_bank),
        .dq_col(dq_col), .pre_req(pre_req), .pre_bank(pre_bank));

    function automatic logic [CW-1:0] beat_col(logic [CW-1:0] s, int j);
        return (s & ~WM) | ((s + CW'(j)) & WM);
    endfunction

    task automatic put(int c, logic [2:0] op, logic b, logic [CW-1:0] col);
        p_cmd[c] = op; p_bank[c] = b; p_col[c] = col;
    endtask

    task automatic set_tag(int lo, int hi, string s);
        for (int t = lo; t <= hi; t++) tag[t] = s;
    endtask

    // Expected table from R2..R9, commands processed in time order.
    task automatic build_expect();
        for (int t = 0; t < NCYC; t++) begin
            e_beat[t] = 0; e_own[t] = -1; e_pre[t] = 0; e_preb[t] = 0;
            e_bank[t] = 0; e_col[t] = '0;
        end
        for (int c = 0; c < NCYC; c++) begin
            case (p_cmd[c])
                3'd1, 3'd2: begin
                    for (int t = c + CL; t < NCYC; t++) e_beat[t] = 0;
                    for (int j = 0; j < BL; j++) begin
                        if (c + CL + j < NCYC) begin
                            e_beat[c+CL+j] = 1; e_own[c+CL+j] = c;
                            e_bank[c+CL+j] = p_bank[c];
                            e_col[c+CL+j]  = beat_col(p_col[c], j);
                        end
                    end
                end
                3'd3, 3'd4: for (int t = c + 1; t < NCYC; t++) e_beat[t] = 0;
                3'd5, 3'd6: for (int t = c + HZ; t < NCYC; t++)
                    if (p_cmd[c] == 3'd6 || e_bank[t] == p_bank[c]) e_beat[t] = 0;
                default: ;
            endcase
        end
        for (int c = 0; c < NCYC; c++) begin
            if (p_cmd[c] == 3'd2) begin
                int f = c + CL + BL - 1;
                if (f + 1 < NCYC && e_beat[f] && e_own[f] == c) begin
                    e_pre[f+1] = 1; e_preb[f+1] = p_bank[c];
                end
            end
            if (p_cmd[c] == 3'd4 && c + BL < NCYC) begin
                bit cancel = 0;
                for (int k = c + 1; k < c + BL; k++)
                    if (p_cmd[k] >= 3'd1 && p_cmd[k] <= 3'd4) cancel = 1;
                if (!cancel) begin e_pre[c+BL] = 1; e_preb[c+BL] = p_bank[c]; end
            end
        end
    endtask

    task automatic check_cycle(int t);
        logic exp_oe;
        exp_oe = e_beat[t] && !(t >= 2 && p_dqm[t-2]) && t >= 5;
        checks++;
        if (dq_oe !== exp_oe) begin
            errors++;
            $display("FAIL %s cycle %0d dq_oe actual %b expected %b", tag[t], t, dq_oe, exp_oe);
        end
        if (exp_oe) begin
            checks++;
            if (dq_col !== e_col[t] || dq_bank !== e_bank[t]) begin
                errors++;
                $display("FAIL %s cycle %0d bank/col actual %b/%h expected %b/%h",
                         tag[t], t, dq_bank, dq_col, e_bank[t], e_col[t]);
            end
        end
        checks++;
        if (pre_req !== e_pre[t] || (e_pre[t] && pre_bank !== e_preb[t])) begin
            errors++;
            $display("FAIL %s cycle %0d pre_req/bank actual %b/%b expected %b/%b",
                     tag[t], t, pre_req, pre_bank, e_pre[t], e_preb[t]);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0A11));
        for (int t = 0; t < NCYC; t++) begin
            put(t, 3'd0, 1'b0, '0); p_dqm[t] = 0; tag[t] = "R2";
        end
        set_tag(0, 8, "R1");                       // R1 reset state
        put(10, 3'd1, 1'b0, 9'h012);              // R2/R3 wrap 12,13,10,11
        set_tag(10, 20, "R3");
        put(30, 3'd1, 1'b1, 9'h040);              // R4 back-to-back reads
        put(31, 3'd1, 1'b1, 9'h085);
        put(50, 3'd1, 1'b0, 9'h020);              // R4 spacing of two
        put(52, 3'd1, 1'b0, 9'h031);
        set_tag(30, 60, "R4");
        put(70, 3'd2, 1'b0, 9'h008);              // R5/R6 write cuts masked read
        put(75, 3'd3, 1'b0, 9'h000);
        p_dqm[72] = 1; p_dqm[73] = 1; p_dqm[74] = 1;
        set_tag(70, 80, "R5");
        put(90, 3'd4, 1'b1, 9'h000);              // R9 write auto-precharge
        set_tag(90, 96, "R9");
        put(100, 3'd2, 1'b1, 9'h1FE);             // R8 read auto-precharge
        set_tag(100, 110, "R8");
        put(120, 3'd1, 1'b0, 9'h100);             // R7 early deactivate
        put(123, 3'd5, 1'b0, 9'h000);
        put(140, 3'd1, 1'b1, 9'h0C1);             // R7 late deactivate-all
        put(145, 3'd6, 1'b0, 9'h000);
        set_tag(120, 150, "R7");
        put(160, 3'd4, 1'b0, 9'h000);             // R9 cancelled by read
        put(162, 3'd1, 1'b0, 9'h000);
        set_tag(160, 170, "R9");
        for (int t = 200; t < 560; t++) begin     // R6 mixed random traffic
            int r = $urandom_range(0, 11);
            if (r < 4) put(t, 3'($urandom_range(1, 4)), 1'($urandom), CW'($urandom));
            p_dqm[t] = ($urandom_range(0, 3) == 0);
            tag[t] = "R6";
        end
        build_expect();

        for (int t = 0; t < NCYC; t++) begin
            @(negedge clk);
            if (t >= 1) check_cycle(t);
            rst_n    = (t >= 4);
            cmd_code = p_cmd[t];
            cmd_bank = p_bank[t];
            cmd_col  = p_col[t];
            dqm      = p_dqm[t];
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(NCYC * 4 + 2000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule